// File: doc/BRIEF.md
# SPI Pad Control and Fault Logic

This block sits between an SPI shift engine and the I/O pads. It holds the port's control bits: port enable, master role, open-drain mode and fault auto-disable. From these bits it produces the output value, the output enable and the open-drain pull-down enable for the MOSI, MISO and SPICLK pads. It also selects which received data and clock the engine sees, and it produces a reset for the engine's internal logic. In open-drain mode the active data pad is never driven. Instead a separate pull-down enable is raised whenever the outgoing bit is 0, and a 1 is left to the external pull-up.

The block watches the slave-select input. If slave-select goes active while this port is an enabled master, another master is driving the bus. The block then sets a sticky fault flag in a status register. If the auto-disable bit is set, it also clears the enable and master bits in hardware, so the pads are released. The status flag is cleared only by writing 1 to it, and clearing the enable bit does not touch it.

Top module: `spi_pad_ctrl`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, and every pad output enable and pull-down enable is 0.
- R2: Register address 0 is control, with bit0 = port enable, bit1 = master role, bit2 = open-drain mode and bit3 = fault auto-disable. Address 1 is status, with bit0 = fault flag. Unused bits read 0. A write takes effect on the clock edge at which regWe is high, and a read is combinational.
- R3: As an enabled master with open-drain 0, mosiOe = 1 and mosiOut = txBit. SPICLK is driven (sclkOe = 1, sclkOut = engSclk), rxBit follows misoIn, and both pull-down enables are 0.
- R4: As an enabled master with open-drain 1, mosiOe = 0, mosiOut = 0 and mosiPadEn = NOT txBit. SPICLK is still driven.
- R5: As an enabled slave with slave-select active (ssN = 0) and open-drain 0, misoOe = 1 and misoOut = txBit. rxBit follows mosiIn, sclkRx follows sclkIn, and mosiOe and sclkOe are 0.
- R6: As an enabled slave with slave-select active and open-drain 1, misoOe = 0, misoOut = 0 and misoPadEn = NOT txBit.
- R7: With the port enable bit 0, all output enables and pull-down enables are 0, and rxBit and sclkRx are 0 whatever the pad inputs are.
- R8: As an enabled slave with ssN = 1, engRstN is 0 and the MISO pad is neither driven nor pulled down.
- R9: engRstN is 1 only for an enabled master, or for an enabled slave with ssN = 0. Clearing the enable bit drives it to 0.
- R10: An enabled master that sees ssN = 0 at a clock edge has the fault flag set after that edge.
- R11: When bit3 is 1, the same edge clears the enable and master bits, and this wins over a control write in that cycle. When bit3 is 0, the control bits are kept.
- R12: Writing 1 to status bit0 clears the flag, and writing 0 to it has no effect. Writing 0xFF clears it. A fault in the same cycle as the clearing write leaves the flag set.
- R13: The fault flag keeps its value when the enable bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data |
| txBit | input | 1 | Outgoing bit from shift engine |
| engSclk | input | 1 | Serial clock from baud generator |
| rxBit | output | 1 | Received bit to shift engine |
| sclkRx | output | 1 | Received serial clock (slave role) |
| engRstN | output | 1 | Engine logic reset, active low |
| ssN | input | 1 | Slave-select pad input, active low |
| mosiIn | input | 1 | MOSI pad input |
| mosiOut | output | 1 | MOSI pad output value |
| mosiOe | output | 1 | MOSI pad output enable |
| mosiPadEn | output | 1 | MOSI open-drain pull-down enable |
| misoIn | input | 1 | MISO pad input |
| misoOut | output | 1 | MISO pad output value |
| misoOe | output | 1 | MISO pad output enable |
| misoPadEn | output | 1 | MISO open-drain pull-down enable |
| sclkIn | input | 1 | SPICLK pad input |
| sclkOut | output | 1 | SPICLK pad output value |
| sclkOe | output | 1 | SPICLK pad output enable |

## Verification
Random control words are combined with random txBit, pad inputs and slave-select. Across these the pad map is tried in all eight combinations of enable, role and open-drain, with both values of txBit. A txBit of 1 against 0 separates push-pull drive from the open-drain pull-down, and different values on misoIn and mosiIn show which pad feeds rxBit. Directed cases cover slave-select inactive in slave role, a fault with and without auto-disable, and a fault in the same cycle as a clearing write. They also check the flag after the port is disabled, so that sticky behaviour is told apart from a reset.

// File: rtl/spi_pad_pkg.sv
`timescale 1ns/1ps
package spi_pad_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam int CTL_W = 4;
  // control field positions
  localparam int B_EN = 0;
  localparam int B_MST = 1;
  localparam int B_OD = 2;
  localparam int B_AUTO = 3;
  localparam int B_FAULT = 0;

  typedef struct packed {
    logic drvMaster;  // enabled master
    logic drvSlave;   // enabled, selected slave
    logic openDrain;
  } padStrobe_t;
endpackage

// File: rtl/spi_pad_regs.sv
`timescale 1ns/1ps
module spi_pad_regs
  import spi_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              ssN,
  output padStrobe_t        strobe,
  output logic              engRstN
);
  logic [CTL_W-1:0] ctrlQ;
  logic             faultQ;
  logic             faultHit;
  logic             ctrlWr;
  logic             statClr;
  logic [DATA_W-1:0] unusedBits;

  assign unusedBits = regWdata;
  assign ctrlWr   = regWe && (regAddr == ADDR_CTRL);
  assign statClr  = regWe && (regAddr == ADDR_STAT) && regWdata[B_FAULT];
  assign faultHit = ctrlQ[B_EN] && ctrlQ[B_MST] && !ssN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else begin
      if (ctrlWr) ctrlQ <= regWdata[CTL_W-1:0];
      if (faultHit && ctrlQ[B_AUTO]) begin
        ctrlQ[B_EN]  <= 1'b0;
        ctrlQ[B_MST] <= 1'b0;
      end
    end
  end

  // sticky flag: only rstN or a write of 1 clears it; setting wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         faultQ <= 1'b0;
    else if (faultHit) faultQ <= 1'b1;
    else if (statClr)  faultQ <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_CTRL)      regRdata[CTL_W-1:0] = ctrlQ;
    else if (regAddr == ADDR_STAT) regRdata[B_FAULT]   = faultQ;
  end

  assign strobe.drvMaster = ctrlQ[B_EN] && ctrlQ[B_MST];
  assign strobe.drvSlave  = ctrlQ[B_EN] && !ctrlQ[B_MST] && !ssN;
  assign strobe.openDrain = ctrlQ[B_OD];
  assign engRstN = strobe.drvMaster || strobe.drvSlave;

  a_r10_fault_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    faultHit |=> faultQ);
  a_r11_auto_disable: assert property (@(posedge clk) disable iff (!rstN)
    (faultHit && ctrlQ[B_AUTO]) |=> (!ctrlQ[B_EN] && !ctrlQ[B_MST]));
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (faultQ && !statClr) |=> faultQ);
  a_r13_disable_keeps_flag: assert property (@(posedge clk) disable iff (!rstN)
    (faultQ && ctrlWr && !regWdata[B_EN]) |=> faultQ);
endmodule

// File: rtl/spi_pad_drive.sv
`timescale 1ns/1ps
module spi_pad_drive
  import spi_pad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  padStrobe_t strobe,
  input  logic       txBit,
  input  logic       engSclk,
  input  logic       mosiIn,
  input  logic       misoIn,
  input  logic       sclkIn,
  input  logic       ssN,
  output logic       rxBit,
  output logic       sclkRx,
  output logic       mosiOut,
  output logic       mosiOe,
  output logic       mosiPadEn,
  output logic       misoOut,
  output logic       misoOe,
  output logic       misoPadEn,
  output logic       sclkOut,
  output logic       sclkOe
);
  logic [1:0] drvSel;
  logic [1:0] pushOut;
  logic [1:0] pushOe;
  logic [1:0] pullEn;

  assign drvSel = {strobe.drvSlave, strobe.drvMaster};

  // index 0 = MOSI (master drives), index 1 = MISO (slave drives)
  for (genvar g = 0; g < 2; g++) begin : g_dataPad
    always_comb begin
      pushOe[g]  = drvSel[g] && !strobe.openDrain;
      pushOut[g] = pushOe[g] && txBit;
      pullEn[g]  = drvSel[g] && strobe.openDrain && !txBit;
    end
  end

  assign mosiOe    = pushOe[0];
  assign mosiOut   = pushOut[0];
  assign mosiPadEn = pullEn[0];
  assign misoOe    = pushOe[1];
  assign misoOut   = pushOut[1];
  assign misoPadEn = pullEn[1];

  assign sclkOe  = strobe.drvMaster;
  assign sclkOut = strobe.drvMaster && engSclk;
  assign sclkRx  = strobe.drvSlave && sclkIn;
  assign rxBit   = strobe.drvMaster ? misoIn : (strobe.drvSlave && mosiIn);

  a_r4_mosi_never_both: assert property (@(posedge clk) disable iff (!rstN)
    !(mosiOe && mosiPadEn));
  a_r6_miso_never_both: assert property (@(posedge clk) disable iff (!rstN)
    !(misoOe && misoPadEn));
  a_r8_unselected_slave_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ssN && !sclkOe) |-> (!misoOe && !misoPadEn && !sclkRx));
  a_r3_single_data_driver: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mosiOe | mosiPadEn, misoOe | misoPadEn}));
endmodule

// File: rtl/spi_pad_ctrl.sv
`timescale 1ns/1ps
module spi_pad_ctrl
  import spi_pad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              txBit,
  input  logic              engSclk,
  output logic              rxBit,
  output logic              sclkRx,
  output logic              engRstN,
  input  logic              ssN,
  input  logic              mosiIn,
  output logic              mosiOut,
  output logic              mosiOe,
  output logic              mosiPadEn,
  input  logic              misoIn,
  output logic              misoOut,
  output logic              misoOe,
  output logic              misoPadEn,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe
);
  padStrobe_t strobe;

  spi_pad_regs i_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .ssN(ssN),
    .strobe(strobe), .engRstN(engRstN)
  );

  spi_pad_drive i_drive (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txBit(txBit), .engSclk(engSclk),
    .mosiIn(mosiIn), .misoIn(misoIn), .sclkIn(sclkIn), .ssN(ssN),
    .rxBit(rxBit), .sclkRx(sclkRx),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .mosiPadEn(mosiPadEn),
    .misoOut(misoOut), .misoOe(misoOe), .misoPadEn(misoPadEn),
    .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  a_r9_engine_reset_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkOe && ssN) |-> !engRstN);
  a_r7_off_pads_released: assert property (@(posedge clk) disable iff (!rstN)
    !engRstN |-> !(mosiOe || misoOe || sclkOe || mosiPadEn || misoPadEn));
endmodule

// File: tb/test_spi_pad_ctrl.sv
`timescale 1ns/1ps
module test_spi_pad_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic txBit = 1'b0, engSclk = 1'b0, ssN = 1'b1;
  logic mosiIn = 1'b0, misoIn = 1'b0, sclkIn = 1'b0;
  logic rxBit, sclkRx, engRstN;
  logic mosiOut, mosiOe, mosiPadEn, misoOut, misoOe, misoPadEn, sclkOut, sclkOe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_pad_ctrl i_spi_pad_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .txBit(txBit), .engSclk(engSclk),
    .rxBit(rxBit), .sclkRx(sclkRx), .engRstN(engRstN), .ssN(ssN),
    .mosiIn(mosiIn), .mosiOut(mosiOut), .mosiOe(mosiOe), .mosiPadEn(mosiPadEn),
    .misoIn(misoIn), .misoOut(misoOut), .misoOe(misoOe), .misoPadEn(misoPadEn),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  function automatic logic [10:0] padNow();
    return {mosiOut, mosiOe, mosiPadEn, misoOut, misoOe, misoPadEn,
            sclkOut, sclkOe, rxBit, sclkRx, engRstN};
  endfunction

  // expected pad vector from R3..R9
  function automatic logic [10:0] padExp(input logic [3:0] c, input logic s,
      input logic tx, input logic sc, input logic mi, input logic mo, input logic si);
    logic m, sl, od;
    m  = c[0] & c[1];
    sl = c[0] & ~c[1] & ~s;
    od = c[2];
    return {m & ~od & tx, m & ~od, m & od & ~tx,
            sl & ~od & tx, sl & ~od, sl & od & ~tx,
            m & sc, m, (m & mi) | (sl & mo), sl & si, m | sl};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(tag, {8'h0, regRdata}, {8'h0, exp});
  endtask

  task automatic chkPads(input string tag, input logic [3:0] c);
    #1;
    check(tag, {5'h0, padNow()}, {5'h0, padExp(c, ssN, txBit, engSclk, misoIn, mosiIn, sclkIn)});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] c;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    // R1 reset state
    rd("R1 ctrl", 2'd0, 8'h00);
    rd("R1 stat", 2'd1, 8'h00);
    chkPads("R1 pads", 4'h0);
    rstN = 1'b1;

    // R2 readback, unused bits zero
    wr(2'd0, 8'hF5);
    rd("R2 ctrl readback", 2'd0, 8'h05);
    rd("R2 unused addr", 2'd2, 8'h00);

    // R7 disabled pads ignore inputs
    wr(2'd0, 8'h06);
    txBit = 1; misoIn = 1; mosiIn = 1; sclkIn = 1; engSclk = 1; ssN = 0;
    chkPads("R7 disabled", 4'h6);
    ssN = 1;

    // R3 / R4 master
    wr(2'd0, 8'h03);
    txBit = 1; misoIn = 1; mosiIn = 0; engSclk = 1;
    chkPads("R3 master push tx1", 4'h3);
    txBit = 0; misoIn = 0; mosiIn = 1; engSclk = 0;
    chkPads("R3 master push tx0", 4'h3);
    wr(2'd0, 8'h07);
    txBit = 0;
    chkPads("R4 master od tx0", 4'h7);
    txBit = 1;
    chkPads("R4 master od tx1", 4'h7);

    // R5 / R6 / R8 slave
    wr(2'd0, 8'h01);
    ssN = 0; txBit = 1; mosiIn = 1; misoIn = 0; sclkIn = 1;
    chkPads("R5 slave push", 4'h1);
    wr(2'd0, 8'h05);
    txBit = 0;
    chkPads("R6 slave od tx0", 4'h5);
    ssN = 1;
    #1;
    check("R8 deselected engRstN", {15'h0, engRstN}, 16'h0);
    chkPads("R8 deselected pads", 4'h5);
    // R9 clearing enable resets engine
    ssN = 0;
    wr(2'd0, 8'h04);
    #1;
    check("R9 disable engRstN", {15'h0, engRstN}, 16'h0);
    ssN = 1;

    // R10 / R11 fault with auto-disable
    wr(2'd0, 8'h0B);
    ssN = 0;
    @(negedge clk);
    ssN = 1;
    rd("R10 flag set", 2'd1, 8'h01);
    rd("R11 auto cleared", 2'd0, 8'h08);
    chkPads("R11 pads released", 4'h8);

    // R13 flag survives disable, R12 zero write no effect
    wr(2'd0, 8'h00);
    rd("R13 flag kept", 2'd1, 8'h01);
    wr(2'd1, 8'hFE);
    rd("R12 write0 no effect", 2'd1, 8'h01);
    wr(2'd1, 8'hFF);
    rd("R12 FF clears", 2'd1, 8'h00);

    // R11 no auto-disable; R12 set wins over clear
    wr(2'd0, 8'h03);
    @(negedge clk);
    ssN = 0;
    regWe = 1; regAddr = 2'd1; regWdata = 8'h01;
    @(negedge clk);
    regWe = 0; ssN = 1;
    rd("R12 set wins", 2'd1, 8'h01);
    rd("R11 bits kept", 2'd0, 8'h03);
    wr(2'd1, 8'h01);
    rd("R12 w1c", 2'd1, 8'h00);

    // R11 fault clear beats simultaneous control write
    wr(2'd0, 8'h0B);
    @(negedge clk);
    ssN = 0;
    regWe = 1; regAddr = 2'd0; regWdata = 8'h0F;
    @(negedge clk);
    regWe = 0; ssN = 1;
    rd("R11 fault beats write", 2'd0, 8'h0C);
    wr(2'd1, 8'hFF);

    // random pad map
    for (int i = 0; i < 300; i++) begin
      c = 4'($urandom) & 4'h7;
      ssN = 1;
      wr(2'd0, {4'h0, c});
      txBit = 1'($urandom); engSclk = 1'($urandom); mosiIn = 1'($urandom);
      misoIn = 1'($urandom); sclkIn = 1'($urandom);
      ssN = (c[0] & c[1]) ? 1'b1 : 1'($urandom);
      chkPads("R3/R4/R5/R6/R7/R8/R9 random map", c);
    end
    ssN = 1;
    rd("R10 no spurious fault", 2'd1, 8'h00);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule